// File: doc/BRIEF.md
# Correlation Pair Index Sequencer

This block produces the ordered stream of point-pair indices that feeds a pairwise histogram engine. A start pulse loads two dataset lengths and a mode bit. The block then issues one (outer, inner) index pair per cycle for as long as the consumer keeps ready high. Each pair is offered through a valid/ready handshake. When the final pair has been taken, a one-cycle completion pulse follows.

The mode bit chooses between two cases. Cross mode pairs every point of dataset A with every point of dataset B. Auto mode pairs one dataset with itself, so each unordered pair appears once and no point is paired with itself. Pairs come out in row-major order: the inner index steps fastest.

Each pair carries a row-start flag, so the downstream engine can restart its bank rotation at the start of every inner sweep. A running count of accepted pairs is also provided.

Top module: `pair_idx_seq`

## Requirements
- R1: After reset, pair_valid_o, done_o and pair_count_o are all 0.
- R2: A start_i pulse taken while idle latches len_a_i, len_b_i and auto_mode_i. In the next cycle pair_valid_o is high with outer_o = 0 and inner_o = 0 in cross mode, or inner_o = 1 in auto mode, provided the pair set is not empty.
- R3: In cross mode (auto_mode_i = 0), outer_o covers 0 to len_a-1 and inner_o covers 0 to len_b-1. The order is row-major: inner_o advances after each accepted pair, and outer_o advances when inner_o wraps.
- R4: In auto mode (auto_mode_i = 1), outer_o covers 0 to len_a-2 and inner_o covers outer_o+1 to len_b-1. Rows whose inner range is empty are skipped, so outer_o never equals inner_o.
- R5: row_first_o is high together with the first pair of each row and low for every other pair.
- R6: While pair_valid_o is high and pair_ready_i is low, pair_valid_o, outer_o, inner_o and row_first_o stay unchanged.
- R7: done_o is high for exactly one cycle, in the cycle after the handshake of the last pair, and pair_valid_o is low in that cycle.
- R8: If the pair set is empty (for example len_a < 2 in auto mode, or len_b = 0 in cross mode), done_o pulses in the cycle after start_i and no pair is issued.
- R9: A start_i pulse during a sweep is ignored. The sweep continues with its latched lengths and mode, and the pair count is not cleared.
- R10: pair_count_o is cleared by an accepted start and rises by one for each handshake. After done_o it holds the total number of pairs in the sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Starts a sweep when the block is idle |
| auto_mode_i | input | 1 | 1 = auto (self) pairing, 0 = cross pairing |
| len_a_i | input | IDX_W | Length of the outer dataset |
| len_b_i | input | IDX_W | Length of the inner dataset |
| pair_ready_i | input | 1 | Consumer accepts the current pair |
| pair_valid_o | output | 1 | A pair is on offer |
| outer_o | output | IDX_W | Outer index |
| inner_o | output | IDX_W | Inner index |
| row_first_o | output | 1 | First pair of a row |
| done_o | output | 1 | One-cycle pulse after the last pair |
| pair_count_o | output | 2*IDX_W | Pairs accepted since the last start |

## Verification
Some properties are checked by assertions on every cycle:
- the pair is held stable while stalled;
- inner_o stays inside its latched bound, and above outer_o in auto mode;
- outer_o never passes the last row;
- done_o is a single-cycle pulse that never coincides with valid;
- the count only moves on a handshake or a start.

Other behaviour can only be shown by the bench's directed scenarios, each of which has a known answer:
- the exact row-major sequence in each mode;
- the row-start flag;
- the truncated set of auto-mode rows when len_b is shorter than len_a;
- the empty-set cases;
- a start pulse injected during a sweep having no effect.

// File: rtl/pair_seq_pkg.sv
// Package: shared state type and helper for the pair sequencer.
// Assumes lengths are unsigned and share one width across the block.
package pair_seq_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // Smaller of two unsigned lengths.
    function automatic logic [31:0] min_len(input logic [31:0] a, input logic [31:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/pair_seq_plan.sv
// pair_seq_plan: works out, from the raw start-time inputs, how many
// non-empty rows a sweep has and where its first inner index sits.
// Assumes: purely combinational; the caller latches the results on start.
module pair_seq_plan #(
    parameter int IDX_W = 16
) (
    input  logic             auto_mode_i,
    input  logic [IDX_W-1:0] len_a_i,
    input  logic [IDX_W-1:0] len_b_i,
    output logic [IDX_W-1:0] rows_o,
    output logic [IDX_W-1:0] first_inner_o
);
    import pair_seq_pkg::*;

    logic [31:0] shorter;

    // Row count: auto rows stop at the shorter length minus one.
    always_comb begin
        shorter = min_len(32'(len_a_i), 32'(len_b_i));
        if (auto_mode_i) begin
            rows_o = (shorter == 32'd0) ? '0 : IDX_W'(shorter - 32'd1);
        end else begin
            rows_o = (len_b_i == '0) ? '0 : len_a_i;
        end
        first_inner_o = auto_mode_i ? IDX_W'(1) : '0;
    end

endmodule

// File: rtl/pair_seq_tally.sv
// pair_seq_tally: counts accepted pairs since the last accepted start.
// Assumes: clear and step never arrive together (start only taken when idle).
module pair_seq_tally #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] count_q;

    // Counter register: clear on start, +1 per handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (clear_i) count_q <= '0;
        else if (step_i)  count_q <= count_q + 1'b1;
    end

    assign count_o = count_q;

    // R10
    count_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !step_i) |=> $stable(count_q));

endmodule

// File: rtl/pair_seq_walk.sv
// pair_seq_walk: the sweep state machine. It holds the latched bounds,
// steps the inner index on each handshake, wraps to the next row, and
// pulses done after the last pair.
// Assumes: rows_i and first_inner_i come from pair_seq_plan for the
// same start inputs; a rows_i of zero means an empty pair set.
module pair_seq_walk #(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             auto_mode_i,
    input  logic [IDX_W-1:0] len_b_i,
    input  logic [IDX_W-1:0] rows_i,
    input  logic [IDX_W-1:0] first_inner_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] outer_o,
    output logic [IDX_W-1:0] inner_o,
    output logic             row_first_o,
    output logic             done_o,
    output logic             start_ok_o,
    output logic             fire_o
);
    import pair_seq_pkg::*;

    seq_state_e       state_q;
    logic             auto_q;
    logic [IDX_W-1:0] lim_b_q;
    logic [IDX_W-1:0] last_row_q;
    logic [IDX_W-1:0] outer_q;
    logic [IDX_W-1:0] inner_q;
    logic             first_q;
    logic             done_q;
    logic             row_end;
    logic             last_row;

    assign valid_o    = (state_q == ST_RUN);
    assign start_ok_o = start_i && (state_q == ST_IDLE);
    assign fire_o     = valid_o && ready_i;
    assign row_end    = (inner_q == lim_b_q - 1'b1);
    assign last_row   = (outer_q == last_row_q);

    // Sweep sequencing: latch on start, advance on handshake, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            auto_q     <= 1'b0;
            lim_b_q    <= '0;
            last_row_q <= '0;
            outer_q    <= '0;
            inner_q    <= '0;
            first_q    <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_ok_o) begin
                auto_q     <= auto_mode_i;
                lim_b_q    <= len_b_i;
                last_row_q <= rows_i - 1'b1;
                outer_q    <= '0;
                inner_q    <= first_inner_i;
                if (rows_i == '0) begin
                    done_q <= 1'b1;
                end else begin
                    state_q <= ST_RUN;
                    first_q <= 1'b1;
                end
            end else if (fire_o) begin
                if (row_end && last_row) begin
                    state_q <= ST_IDLE;
                    first_q <= 1'b0;
                    done_q  <= 1'b1;
                end else if (row_end) begin
                    outer_q <= outer_q + 1'b1;
                    inner_q <= auto_q ? (outer_q + IDX_W'(2)) : '0;
                    first_q <= 1'b1;
                end else begin
                    inner_q <= inner_q + 1'b1;
                    first_q <= 1'b0;
                end
            end
        end
    end

    assign outer_o     = outer_q;
    assign inner_o     = inner_q;
    assign row_first_o = first_q;
    assign done_o      = done_q;

    // R6
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(outer_q) && $stable(inner_q) && $stable(first_q)));

    // R3
    inner_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (inner_q < lim_b_q));

    // R4
    no_self_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && auto_q) |-> (inner_q > outer_q));

    // R3
    outer_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (outer_q <= last_row_q));

    // R7
    done_not_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !valid_o);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/pair_idx_seq.sv
// pair_idx_seq: top of the correlation pair index sequencer. It issues
// (outer, inner) index pairs in row-major order over a valid/ready
// handshake, in auto (self) or cross pairing mode.
// Assumes: lengths fit IDX_W bits; start is only honoured while idle.
module pair_idx_seq #(
    parameter int IDX_W = 16,
    localparam int CNT_W = 2 * IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             auto_mode_i,
    input  logic [IDX_W-1:0] len_a_i,
    input  logic [IDX_W-1:0] len_b_i,
    input  logic             pair_ready_i,
    output logic             pair_valid_o,
    output logic [IDX_W-1:0] outer_o,
    output logic [IDX_W-1:0] inner_o,
    output logic             row_first_o,
    output logic             done_o,
    output logic [CNT_W-1:0] pair_count_o
);
    logic [IDX_W-1:0] rows;
    logic [IDX_W-1:0] first_inner;
    logic             start_ok;
    logic             fire;

    pair_seq_plan #(.IDX_W(IDX_W)) plan_i (
        .auto_mode_i   (auto_mode_i),
        .len_a_i       (len_a_i),
        .len_b_i       (len_b_i),
        .rows_o        (rows),
        .first_inner_o (first_inner)
    );

    pair_seq_walk #(.IDX_W(IDX_W)) walk_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .auto_mode_i   (auto_mode_i),
        .len_b_i       (len_b_i),
        .rows_i        (rows),
        .first_inner_i (first_inner),
        .ready_i       (pair_ready_i),
        .valid_o       (pair_valid_o),
        .outer_o       (outer_o),
        .inner_o       (inner_o),
        .row_first_o   (row_first_o),
        .done_o        (done_o),
        .start_ok_o    (start_ok),
        .fire_o        (fire)
    );

    pair_seq_tally #(.CNT_W(CNT_W)) tally_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_ok),
        .step_i  (fire),
        .count_o (pair_count_o)
    );

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid_o && start_i && !pair_ready_i) |=> ($stable(outer_o) && $stable(inner_o)));

endmodule

// File: tb/pair_idx_seq_tb.sv
// Directed bench for pair_idx_seq: one task per scenario, each checking
// its own results against a model of the requirements.
module pair_idx_seq_tb_top;
    localparam int IDX_W = 16;
    localparam int CNT_W = 2 * IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             auto_mode_i = 1'b0;
    logic [IDX_W-1:0] len_a_i = '0;
    logic [IDX_W-1:0] len_b_i = '0;
    logic             pair_ready_i = 1'b0;
    logic             pair_valid_o;
    logic [IDX_W-1:0] outer_o;
    logic [IDX_W-1:0] inner_o;
    logic             row_first_o;
    logic             done_o;
    logic [CNT_W-1:0] pair_count_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pair_idx_seq #(.IDX_W(IDX_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .auto_mode_i  (auto_mode_i),
        .len_a_i      (len_a_i),
        .len_b_i      (len_b_i),
        .pair_ready_i (pair_ready_i),
        .pair_valid_o (pair_valid_o),
        .outer_o      (outer_o),
        .inner_o      (inner_o),
        .row_first_o  (row_first_o),
        .done_o       (done_o),
        .pair_count_o (pair_count_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    // Issue a start pulse; outputs reflect it at the following negedge.
    task automatic kick(input bit am, input int n1, input int n2);
        @(negedge clk);
        auto_mode_i = am;
        len_a_i = IDX_W'(n1);
        len_b_i = IDX_W'(n2);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Full sweep with the expected row-major order; optional stalls and a
    // start pulse injected during a stall.
    task automatic sweep(input bit am, input int n1, input int n2,
                         input bit stall, input bit inject, input string req);
        int total = 0;
        bit injected = 0;
        kick(am, n1, n2);
        for (int i = 0; i < (am ? n1 - 1 : n1); i++) begin
            for (int j = (am ? i + 1 : 0); j < n2; j++) begin
                if (stall && (j % 2 == 0)) begin
                    pair_ready_i = 1'b0;
                    if (inject && !injected) begin
                        start_i = 1'b1;
                        auto_mode_i = ~am;
                        len_a_i = IDX_W'(2);
                        len_b_i = IDX_W'(2);
                    end
                    @(negedge clk);
                    if (inject && !injected) begin
                        start_i = 1'b0;
                        injected = 1;
                        check("R9 count kept", pair_count_o, total);
                    end
                    check("R6 valid held", pair_valid_o, 1);
                    check("R6 outer held", outer_o, i);
                    check("R6 inner held", inner_o, j);
                end
                check({req, " valid"}, pair_valid_o, 1);
                check({req, " outer"}, outer_o, i);
                check({req, " inner"}, inner_o, j);
                check("R5 row_first", row_first_o, (j == (am ? i + 1 : 0)));
                check("R7 no early done", done_o, 0);
                pair_ready_i = 1'b1;
                @(negedge clk);
                total++;
            end
        end
        pair_ready_i = 1'b0;
        check("R7 done pulse", done_o, 1);
        check("R7 valid low at done", pair_valid_o, 0);
        check("R10 total count", pair_count_o, total);
        @(negedge clk);
        check("R7 done one cycle", done_o, 0);
        check("R10 count held", pair_count_o, total);
    endtask

    task automatic empty_case(input bit am, input int n1, input int n2);
        kick(am, n1, n2);
        check("R8 done on empty", done_o, 1);
        check("R8 no valid", pair_valid_o, 0);
        check("R10 cleared on start", pair_count_o, 0);
        @(negedge clk);
        check("R8 still no valid", pair_valid_o, 0);
        check("R8 done one cycle", done_o, 0);
    endtask

    task automatic reset_case();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid", pair_valid_o, 0);
        check("R1 done", done_o, 0);
        check("R1 count", pair_count_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        reset_case();
        sweep(1'b0, 3, 4, 1'b0, 1'b0, "R2 R3 cross");
        sweep(1'b1, 5, 5, 1'b1, 1'b1, "R4 auto");
        sweep(1'b1, 6, 3, 1'b0, 1'b0, "R4 auto short b");
        sweep(1'b0, 1, 1, 1'b0, 1'b0, "R3 single pair");
        sweep(1'b0, 2, 5, 1'b1, 1'b0, "R3 cross stalled");
        empty_case(1'b1, 1, 8);
        empty_case(1'b0, 4, 0);
        empty_case(1'b1, 5, 1);
        sweep(1'b1, 2, 2, 1'b0, 1'b0, "R4 auto minimal");
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule